// File: doc/BRIEF.md
# Branch Target and Static Prediction Unit

This block sits at the front of an instruction fetch path for a fixed-width 32-bit instruction stream. Each cycle it takes the address of the current instruction, the instruction word, the present link-register and count-register values and a small decode from the option field. From these it forms the predicted address of the next instruction. It handles plain sequential flow, immediate branches (relative or absolute), and branches whose destination is held in the link register or the count register. It also produces a static taken or not-taken guess and a request to write the return address into the link register.

Immediate displacements are word offsets. Each gets two zero bits appended and is then sign-extended to the address width. The guess for a conditional immediate branch follows the sign of its displacement: backward is taken, forward is not. A branch that tests no condition at all is always guessed taken. One override input inverts the default guess of a branch that does test a condition. All outputs are registered, so a result appears one clock after its inputs are sampled.

Top module: `brnext_unit`

## Requirements
- R1: While `rst_n` is low, `nia`, `pred_taken`, `lr_we` and `lr_wdata` are all zero.
- R2: The block treats an instruction as a non-branch when its primary opcode `instr[31:26]` is not 16, 18 or 19, or when the opcode is 19 with `reg_tgt_sel` equal to 00 or 11. For a non-branch, `nia` is `cia + 4`, and `pred_taken` and `lr_we` are 0.
- R3: Opcode 18 is an unconditional immediate branch. Its 24-bit field `instr[25:2]` gets 00 appended and is sign-extended to 32 bits. When `instr[1]` is 0, the target is that value plus `cia`; when `instr[1]` is 1, the target is that value alone. `pred_taken` is 1 whatever the test and override inputs are.
- R4: Opcode 16 is a conditional immediate branch. Its target uses the 14-bit field `instr[15:2]`, extended and selected by `instr[1]` in the same way as in R3.
- R5: For opcode 16, if `tests_cr` or `tests_ctr` is 1, `pred_taken` equals `instr[15]` XOR `pred_flip`. If both are 0, `pred_taken` is 1 and `pred_flip` has no effect.
- R6: Opcode 19 with `reg_tgt_sel` = 01 targets `lr_in`, and with `reg_tgt_sel` = 10 it targets `ctr_in`. In both cases the two low bits are forced to zero and `instr[1]` is ignored.
- R7: For a register-target branch, `pred_taken` is 1 when neither `tests_cr` nor `tests_ctr` is set. Otherwise it equals `pred_flip`.
- R8: Whenever `pred_taken` is 0, `nia` is `cia + 4`. Whenever it is 1, `nia` is the branch target.
- R9: For any branch kind, `lr_we` equals `instr[0]`, and `lr_wdata` is `cia + 4` when `lr_we` is 1 and zero otherwise. For a non-branch, `lr_we` is 0 even when `instr[0]` is 1.
- R10: Every output reflects the inputs sampled at the previous rising clock edge.
- R11: All address arithmetic wraps modulo 2^32. For example, `cia` = 0xFFFFFFFC on a non-branch gives `nia` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cia | input | 32 | Address of the current instruction |
| instr | input | 32 | Current instruction word |
| lr_in | input | 32 | Present link-register value |
| ctr_in | input | 32 | Present count-register value |
| reg_tgt_sel | input | 2 | For opcode 19: 01 selects the link register, 10 the count register, any other value marks a non-branch |
| tests_cr | input | 1 | Branch tests a condition-register bit |
| tests_ctr | input | 1 | Branch decrements and tests the count register |
| pred_flip | input | 1 | Inverts the default guess of a branch that tests a condition |
| nia | output | 32 | Predicted next instruction address |
| pred_taken | output | 1 | Static guess: 1 means taken |
| lr_we | output | 1 | Link-register write request |
| lr_wdata | output | 32 | Return address to write, zero when no write |

## Verification
A wrong extension width or a wrong sign bit shows up one clock later as a target that is off by a power of two, or that points forward where it should point backward. A wrong absolute/relative choice shows the current address added in, or left out. A decode or prediction fault shows on `pred_taken`, and it also moves `nia` between the target and the fall-through address. Because each result is visible at the ports exactly one cycle after its instruction, every fault is caught on the first instruction that exercises it. Random opcodes, displacement signs and test/override combinations cover every path. Directed cases add address wrap, misaligned register values and link bits on non-branches.

// File: rtl/brnext_pkg.sv
package brnext_pkg;

   typedef enum logic [2:0] {
      BK_SEQ     = 3'd0,
      BK_UNC_IMM = 3'd1,
      BK_CND_IMM = 3'd2,
      BK_REG_LR  = 3'd3,
      BK_REG_CTR = 3'd4
   } br_kind_e;

   localparam int unsigned OPC_W    = 6;
   localparam int unsigned DISP_SHL = 2;

   localparam logic [1:0] SEL_LR  = 2'b01;
   localparam logic [1:0] SEL_CTR = 2'b10;

endpackage

// File: rtl/brnext_decode.sv
module brnext_decode
   import brnext_pkg::*;
#(
   parameter int unsigned OPC_UNC = 18,
   parameter int unsigned OPC_CND = 16,
   parameter int unsigned OPC_REG = 19
) (
   input  logic [OPC_W-1:0] opc,
   input  logic [1:0]       reg_sel,
   output br_kind_e         kind
);

   localparam logic [OPC_W-1:0] C_UNC = OPC_W'(OPC_UNC);
   localparam logic [OPC_W-1:0] C_CND = OPC_W'(OPC_CND);
   localparam logic [OPC_W-1:0] C_REG = OPC_W'(OPC_REG);

   always_comb begin
      kind = BK_SEQ;
      if (opc == C_UNC) begin
         kind = BK_UNC_IMM;
      end else if (opc == C_CND) begin
         kind = BK_CND_IMM;
      end else if (opc == C_REG) begin
         case (reg_sel)
            SEL_LR:  kind = BK_REG_LR;
            SEL_CTR: kind = BK_REG_CTR;
            default: kind = BK_SEQ;
         endcase
      end
   end

endmodule

// File: rtl/brnext_immext.sv
module brnext_immext #(
   parameter int unsigned FIELD_W = 24,
   parameter int unsigned SHIFT   = 2,
   parameter int unsigned ADDR_W  = 32
) (
   input  logic [FIELD_W-1:0] fld,
   output logic [ADDR_W-1:0]  ext
);

   localparam int unsigned PAD_W = ADDR_W - FIELD_W - SHIFT;

   if (ADDR_W < FIELD_W + SHIFT) begin : g_bad_width
      $error("brnext_immext: ADDR_W too small for field plus shift");
   end

   if (PAD_W == 0) begin : g_nopad
      assign ext = {fld, {SHIFT{1'b0}}};
   end else begin : g_pad
      assign ext = {{PAD_W{fld[FIELD_W-1]}}, fld, {SHIFT{1'b0}}};
   end

endmodule

// File: rtl/brnext_target.sv
module brnext_target
   import brnext_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned ALIGN_BITS = 2
) (
   input  br_kind_e          kind,
   input  logic              abs_sel,
   input  logic [ADDR_W-1:0] cia,
   input  logic [ADDR_W-1:0] seq_addr,
   input  logic [ADDR_W-1:0] li_ext,
   input  logic [ADDR_W-1:0] bd_ext,
   input  logic [ADDR_W-1:0] lr_val,
   input  logic [ADDR_W-1:0] ctr_val,
   output logic [ADDR_W-1:0] target
);

   localparam logic [ADDR_W-1:0] REG_MASK = ~((ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1));

   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] disp;
   logic [ADDR_W-1:0] imm_tgt;

   assign base    = abs_sel ? '0 : cia;
   assign disp    = (kind == BK_UNC_IMM) ? li_ext : bd_ext;
   assign imm_tgt = base + disp;

   always_comb begin
      case (kind)
         BK_UNC_IMM, BK_CND_IMM: target = imm_tgt;
         BK_REG_LR:              target = lr_val & REG_MASK;
         BK_REG_CTR:             target = ctr_val & REG_MASK;
         default:                target = seq_addr;
      endcase
   end

endmodule

// File: rtl/brnext_predict.sv
module brnext_predict
   import brnext_pkg::*;
(
   input  br_kind_e kind,
   input  logic     tests_cr,
   input  logic     tests_ctr,
   input  logic     disp_neg,
   input  logic     flip,
   output logic     taken
);

   logic tests_any;
   assign tests_any = tests_cr | tests_ctr;

   always_comb begin
      case (kind)
         BK_UNC_IMM:            taken = 1'b1;
         BK_CND_IMM:            taken = tests_any ? (disp_neg ^ flip) : 1'b1;
         BK_REG_LR, BK_REG_CTR: taken = tests_any ? flip : 1'b1;
         default:               taken = 1'b0;
      endcase
   end

endmodule

// File: rtl/brnext_unit.sv
module brnext_unit
   import brnext_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned INSTR_W    = 32,
   parameter int unsigned OPC_UNC    = 18,
   parameter int unsigned OPC_CND    = 16,
   parameter int unsigned OPC_REG    = 19,
   parameter int unsigned ALIGN_BITS = 2,
   parameter bit          REG_OUT    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  cia,
   input  logic [INSTR_W-1:0] instr,
   input  logic [ADDR_W-1:0]  lr_in,
   input  logic [ADDR_W-1:0]  ctr_in,
   input  logic [1:0]         reg_tgt_sel,
   input  logic               tests_cr,
   input  logic               tests_ctr,
   input  logic               pred_flip,
   output logic [ADDR_W-1:0]  nia,
   output logic               pred_taken,
   output logic               lr_we,
   output logic [ADDR_W-1:0]  lr_wdata
);

   // Field positions in big-endian bit numbering (bit 0 = MSB).
   localparam int unsigned LI_FIRST = 6;
   localparam int unsigned LI_LAST  = 29;
   localparam int unsigned BD_FIRST = 16;
   localparam int unsigned BD_LAST  = 29;
   localparam int unsigned AA_POS   = 30;
   localparam int unsigned LK_POS   = 31;

   localparam int unsigned LI_W   = LI_LAST - LI_FIRST + 1;
   localparam int unsigned BD_W   = BD_LAST - BD_FIRST + 1;
   localparam int unsigned LI_HI  = INSTR_W - 1 - LI_FIRST;
   localparam int unsigned BD_HI  = INSTR_W - 1 - BD_FIRST;
   localparam int unsigned AA_IDX = INSTR_W - 1 - AA_POS;
   localparam int unsigned LK_IDX = INSTR_W - 1 - LK_POS;
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_W / 8);

   if (INSTR_W != 32) begin : g_bad_instr
      $error("brnext_unit: instruction width must be 32");
   end
   if (ADDR_W < LI_W + DISP_SHL) begin : g_bad_addr
      $error("brnext_unit: address width too small for the immediate field");
   end
   if (ALIGN_BITS >= ADDR_W) begin : g_bad_align
      $error("brnext_unit: alignment wider than address");
   end

   br_kind_e          kind;
   logic [ADDR_W-1:0] li_ext;
   logic [ADDR_W-1:0] bd_ext;
   logic [ADDR_W-1:0] seq_addr;
   logic [ADDR_W-1:0] target;
   logic              taken_c;
   logic [ADDR_W-1:0] nia_c;
   logic              lr_we_c;
   logic [ADDR_W-1:0] lr_wd_c;

   assign seq_addr = cia + STEP;

   brnext_decode #(
      .OPC_UNC (OPC_UNC),
      .OPC_CND (OPC_CND),
      .OPC_REG (OPC_REG)
   ) u_decode (
      .opc     (instr[INSTR_W-1 -: OPC_W]),
      .reg_sel (reg_tgt_sel),
      .kind    (kind)
   );

   brnext_immext #(
      .FIELD_W (LI_W),
      .SHIFT   (DISP_SHL),
      .ADDR_W  (ADDR_W)
   ) u_li_ext (
      .fld (instr[LI_HI -: LI_W]),
      .ext (li_ext)
   );

   brnext_immext #(
      .FIELD_W (BD_W),
      .SHIFT   (DISP_SHL),
      .ADDR_W  (ADDR_W)
   ) u_bd_ext (
      .fld (instr[BD_HI -: BD_W]),
      .ext (bd_ext)
   );

   brnext_target #(
      .ADDR_W     (ADDR_W),
      .ALIGN_BITS (ALIGN_BITS)
   ) u_target (
      .kind     (kind),
      .abs_sel  (instr[AA_IDX]),
      .cia      (cia),
      .seq_addr (seq_addr),
      .li_ext   (li_ext),
      .bd_ext   (bd_ext),
      .lr_val   (lr_in),
      .ctr_val  (ctr_in),
      .target   (target)
   );

   brnext_predict u_predict (
      .kind      (kind),
      .tests_cr  (tests_cr),
      .tests_ctr (tests_ctr),
      .disp_neg  (instr[BD_HI]),
      .flip      (pred_flip),
      .taken     (taken_c)
   );

   assign nia_c   = taken_c ? target : seq_addr;
   assign lr_we_c = (kind != BK_SEQ) && instr[LK_IDX];
   assign lr_wd_c = lr_we_c ? seq_addr : '0;

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            nia        <= '0;
            pred_taken <= 1'b0;
            lr_we      <= 1'b0;
            lr_wdata   <= '0;
         end else begin
            nia        <= nia_c;
            pred_taken <= taken_c;
            lr_we      <= lr_we_c;
            lr_wdata   <= lr_wd_c;
         end
      end
   end else begin : g_comb
      assign nia        = rst_n ? nia_c   : '0;
      assign pred_taken = rst_n & taken_c;
      assign lr_we      = rst_n & lr_we_c;
      assign lr_wdata   = rst_n ? lr_wd_c : '0;
   end

endmodule

// File: rtl/brnext_unit_chk.sv
module brnext_unit_chk #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned INSTR_W = 32,
   parameter int unsigned OPC_UNC = 18,
   parameter int unsigned OPC_CND = 16,
   parameter int unsigned OPC_REG = 19,
   parameter bit          REG_OUT = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  cia,
   input logic [INSTR_W-1:0] instr,
   input logic [1:0]         reg_tgt_sel,
   input logic               tests_cr,
   input logic               tests_ctr,
   input logic               pred_flip,
   input logic [ADDR_W-1:0]  nia,
   input logic               pred_taken,
   input logic               lr_we,
   input logic [ADDR_W-1:0]  lr_wdata
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_W / 8);

   logic       past_ok;
   logic [5:0] opc;
   logic       is_unc;
   logic       is_cnd;
   logic       is_reg;
   logic       is_nonbr;
   logic       cnd_guess;
   logic [ADDR_W-1:0] seq_chk;

   assign opc       = instr[INSTR_W-1 -: 6];
   assign is_unc    = (opc == 6'(OPC_UNC));
   assign is_cnd    = (opc == 6'(OPC_CND));
   assign is_reg    = (opc == 6'(OPC_REG)) && (reg_tgt_sel == 2'b01 || reg_tgt_sel == 2'b10);
   assign is_nonbr  = !is_unc && !is_cnd && !is_reg;
   assign cnd_guess = (tests_cr || tests_ctr) ? (instr[15] ^ pred_flip) : 1'b1;
   assign seq_chk   = cia + STEP;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   if (REG_OUT) begin : g_props
      // R2
      p_seq_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
         past_ok && $past(is_nonbr) |-> (nia == $past(seq_chk)) && !pred_taken && !lr_we);

      // R3
      p_uncond_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
         past_ok && $past(is_unc) |-> pred_taken);

      // R5
      p_cond_guess_r5: assert property (@(posedge clk) disable iff (!rst_n)
         past_ok && $past(is_cnd) |-> pred_taken == $past(cnd_guess));

      // R6
      p_reg_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
         past_ok && $past(is_reg) && pred_taken |-> nia[1:0] == 2'b00);

      // R8
      p_fallthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
         past_ok && !pred_taken |-> nia == $past(seq_chk));

      // R9
      p_link_val_r9: assert property (@(posedge clk) disable iff (!rst_n)
         past_ok && lr_we |-> lr_wdata == $past(seq_chk));

      // R9
      p_link_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
         past_ok && !$past(instr[0]) |-> !lr_we && lr_wdata == '0);
   end

endmodule

bind brnext_unit brnext_unit_chk #(
   .ADDR_W  (ADDR_W),
   .INSTR_W (INSTR_W),
   .OPC_UNC (OPC_UNC),
   .OPC_CND (OPC_CND),
   .OPC_REG (OPC_REG),
   .REG_OUT (REG_OUT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cia         (cia),
   .instr       (instr),
   .reg_tgt_sel (reg_tgt_sel),
   .tests_cr    (tests_cr),
   .tests_ctr   (tests_ctr),
   .pred_flip   (pred_flip),
   .nia         (nia),
   .pred_taken  (pred_taken),
   .lr_we       (lr_we),
   .lr_wdata    (lr_wdata)
);

// File: tb/brnext_unit_bench.sv
module brnext_unit_bench;

   localparam int CLK_PERIOD = 10;
   localparam int N_RANDOM   = 600;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cia = '0;
   logic [31:0] instr = '0;
   logic [31:0] lr_in = '0;
   logic [31:0] ctr_in = '0;
   logic [1:0]  reg_tgt_sel = '0;
   logic        tests_cr = 1'b0;
   logic        tests_ctr = 1'b0;
   logic        pred_flip = 1'b0;
   logic [31:0] nia;
   logic        pred_taken;
   logic        lr_we;
   logic [31:0] lr_wdata;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   brnext_unit u_brnext_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .cia         (cia),
      .instr       (instr),
      .lr_in       (lr_in),
      .ctr_in      (ctr_in),
      .reg_tgt_sel (reg_tgt_sel),
      .tests_cr    (tests_cr),
      .tests_ctr   (tests_ctr),
      .pred_flip   (pred_flip),
      .nia         (nia),
      .pred_taken  (pred_taken),
      .lr_we       (lr_we),
      .lr_wdata    (lr_wdata)
   );

   task automatic check32(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Reference model written from the requirements.
   function automatic void model(
      input  logic [31:0] m_cia, m_instr, m_lr, m_ctr,
      input  logic [1:0]  m_sel,
      input  logic        m_tcr, m_tctr, m_flip,
      output logic [31:0] e_nia,
      output logic        e_pred,
      output logic        e_we,
      output logic [31:0] e_wd,
      output string       tag);
      logic [5:0]         opc;
      logic signed [25:0] li_s;
      logic signed [15:0] bd_s;
      logic [31:0]        li_x, bd_x, base, seq, tgt;
      logic               is_br, any;
      opc   = m_instr[31:26];
      li_s  = {m_instr[25:2], 2'b00};
      bd_s  = {m_instr[15:2], 2'b00};
      li_x  = 32'(li_s);
      bd_x  = 32'(bd_s);
      base  = m_instr[1] ? 32'h0 : m_cia;
      seq   = m_cia + 32'd4;
      any   = m_tcr | m_tctr;
      is_br = 1'b1;
      tgt   = seq;
      if (opc == 6'd18) begin
         tgt = base + li_x; e_pred = 1'b1; tag = "R3";
      end else if (opc == 6'd16) begin
         tgt = base + bd_x; e_pred = any ? (m_instr[15] ^ m_flip) : 1'b1; tag = "R5";
      end else if (opc == 6'd19 && m_sel == 2'b01) begin
         tgt = m_lr & 32'hFFFF_FFFC; e_pred = any ? m_flip : 1'b1; tag = "R6";
      end else if (opc == 6'd19 && m_sel == 2'b10) begin
         tgt = m_ctr & 32'hFFFF_FFFC; e_pred = any ? m_flip : 1'b1; tag = "R7";
      end else begin
         is_br = 1'b0; e_pred = 1'b0; tag = "R2";
      end
      e_nia = e_pred ? tgt : seq;
      e_we  = is_br & m_instr[0];
      e_wd  = e_we ? seq : 32'h0;
   endfunction

   // Drive at a falling edge, result registered at the next rising edge (R10),
   // sampled at the falling edge after it.
   task automatic apply(input logic [31:0] a_cia, a_instr, a_lr, a_ctr,
                        input logic [1:0] a_sel,
                        input logic a_tcr, a_tctr, a_flip);
      logic [31:0] e_nia, e_wd;
      logic        e_pred, e_we;
      string       tag;
      cia = a_cia; instr = a_instr; lr_in = a_lr; ctr_in = a_ctr;
      reg_tgt_sel = a_sel; tests_cr = a_tcr; tests_ctr = a_tctr; pred_flip = a_flip;
      model(a_cia, a_instr, a_lr, a_ctr, a_sel, a_tcr, a_tctr, a_flip,
            e_nia, e_pred, e_we, e_wd, tag);
      @(posedge clk);
      @(negedge clk);
      check32(tag,  "nia (R8 R10)", nia, e_nia);
      check32(tag,  "pred_taken",   {31'd0, pred_taken}, {31'd0, e_pred});
      check32("R9", "lr_we",        {31'd0, lr_we}, {31'd0, e_we});
      check32("R9", "lr_wdata",     lr_wdata, e_wd);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      // R1: reset state with busy inputs
      cia = 32'h1000; instr = {6'd18, 26'h3FF_FFFD}; lr_in = 32'hABCD_0003;
      repeat (3) @(negedge clk);
      check32("R1", "nia reset",      nia, 32'h0);
      check32("R1", "pred reset",     {31'd0, pred_taken}, 32'h0);
      check32("R1", "lr_we reset",    {31'd0, lr_we}, 32'h0);
      check32("R1", "lr_wdata reset", lr_wdata, 32'h0);
      rst_n = 1'b1;

      // R2 and R11: non-branch at the top of the space wraps to zero
      apply(32'hFFFF_FFFC, {6'd31, 26'h0000001}, 32'h0, 32'h0, 2'b00, 1'b0, 1'b0, 1'b0);
      // R2: opcode 19 with selector 11 is not a branch, link bit set is ignored (R9)
      apply(32'h0000_2000, {6'd19, 26'h0000001}, 32'h4444_4444, 32'h5555_5555, 2'b11, 1'b1, 1'b0, 1'b1);
      // R3: backward relative, link set
      apply(32'h0000_1000, {6'd18, 24'hFFFFFC, 1'b0, 1'b1}, 32'h0, 32'h0, 2'b00, 1'b1, 1'b1, 1'b1);
      // R3: absolute negative field
      apply(32'h0000_1000, {6'd18, 24'h800000, 1'b1, 1'b0}, 32'h0, 32'h0, 2'b00, 1'b0, 1'b0, 1'b0);
      // R4 R5: conditional backward, tests CR, no flip -> taken
      apply(32'h0000_3000, {6'd16, 10'h0, 14'h3FF0, 1'b0, 1'b0}, 32'h0, 32'h0, 2'b00, 1'b1, 1'b0, 1'b0);
      // R5: conditional forward with flip -> taken
      apply(32'h0000_3000, {6'd16, 10'h0, 14'h0010, 1'b0, 1'b1}, 32'h0, 32'h0, 2'b00, 1'b0, 1'b1, 1'b1);
      // R5: tests nothing, forward, flip has no effect -> taken
      apply(32'h0000_3000, {6'd16, 10'h0, 14'h0010, 1'b1, 1'b0}, 32'h0, 32'h0, 2'b00, 1'b0, 1'b0, 1'b1);
      // R5 R8: backward with flip -> not taken, falls through
      apply(32'h0000_3000, {6'd16, 10'h0, 14'h3FF0, 1'b0, 1'b0}, 32'h0, 32'h0, 2'b00, 1'b1, 1'b0, 1'b1);
      // R6 R7: to LR, low bits cleared, AA bit ignored
      apply(32'h0000_4000, {6'd19, 24'h0, 1'b1, 1'b1}, 32'h1234_5677, 32'h0, 2'b01, 1'b0, 1'b0, 1'b0);
      // R6 R7: to CTR, tests set, no flip -> not taken
      apply(32'h0000_4000, {6'd19, 26'h0}, 32'h0, 32'h8000_0002, 2'b10, 1'b1, 1'b0, 1'b0);
      // R6 R7: to CTR, tests set, flip -> taken
      apply(32'h0000_4000, {6'd19, 26'h0}, 32'h0, 32'h8000_0002, 2'b10, 1'b1, 1'b0, 1'b1);

      // Random mix
      for (int i = 0; i < N_RANDOM; i++) begin
         logic [31:0] r_instr;
         logic [5:0]  r_opc;
         int          pick;
         pick = $urandom_range(0, 3);
         r_instr = $urandom();
         case (pick)
            0:       r_opc = 6'd16;
            1:       r_opc = 6'd18;
            2:       r_opc = 6'd19;
            default: r_opc = r_instr[31:26];
         endcase
         apply({$urandom()}, {r_opc, r_instr[25:0]}, {$urandom()}, {$urandom()},
               2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end
      finish_run();
   end

endmodule